// File: doc/BRIEF.md
# NAND Flash Opcode Sequencer

This block runs a short program of NAND bus micro-operations that software composes from a list of up to nine 4-bit opcodes. Each opcode is one step: a command byte taken from one of four command slots, a column address, a row address, a data read or write burst, or a status read. The block drives an 8-bit NAND bus with command latch, address latch, write and read strobes, and per-bank chip enables. It watches the ready/busy line before every data and status step.

A start pulse copies the program, the command bytes, the addresses, the byte count, the bank select and the timeout limit into the block. The steps then run in slot order. A normal end raises a completion event. If the ready/busy line stays low too long, a timeout error event is raised instead. If a write burst is reached while the device is write-protected, a write-protect error event is raised instead. Each of the three events can be routed to a single interrupt output. Read bytes stream out with a valid strobe. Write bytes are taken from a data input. A status read leaves the device's status byte in the top byte of a 32-bit status word.

Every bus byte takes two clocks: one with the strobe low and one with it high. The command and address latch lines are held through both clocks.

Top module: `nand_opseq`

## Requirements
- R1: After reset the block is idle (`busy_o`=0). All events and `irq_o` are 0, `we_n_o`, `re_n_o` and every `ce_n_o` bit are 1, and `status_o` is 0.
- R2: Slot k of `ops_i` is bits [4k+3:4k]. Codes: 0 no-op, 1–4 command from slot 0–3 of `cmd_i` (slot j is bits [8j+7:8j], sent with the command latch high), 5 column, 6 row, 7 wait-then-read, 8 wait-then-write, 9 wait-then-status. Codes 10–15 act as the no-op. Slots run in order. A no-op or the end of slot 8 finishes the run and sets `ev_done_o`.
- R3: A column step sends two address bytes, low byte first. A row step sends the three bytes of `row_i`, low byte first. All address bytes are sent with the address latch high.
- R4: When `col_i[12]` is set, the column sent is `col_i[11:0]` plus PAGE_BYTES, so that it points into the spare area.
- R5: A read step waits until `rb_n_i` is high, then reads `cnt_i` bytes, or PAGE_BYTES+SPARE_BYTES bytes when `cnt_i` is 0. Each byte appears on `rd_data_o` with `rd_valid_o`.
- R6: A write step waits for ready, then sends bytes taken from `wr_data_i` with both latch lines low. The byte count rule is the same as in R5.
- R7: A status step waits for ready and reads one byte. That byte goes to `status_o[31:24]` and bits [23:0] become 0. Nothing appears on `rd_valid_o`.
- R8: If `rb_n_i` stays low for more than `tmo_i` cycles of a wait, `ev_tmo_o` is set, the run ends without `ev_done_o`, and no further bus byte is sent.
- R9: A write step reached while `wp_n_i` is 0 sets `ev_wp_o` and ends the run without `ev_done_o`. No write byte and no later step is sent.
- R10: `irq_o` is the OR of the events masked by `irq_en_i`. Bit 0 enables done, bit 1 enables timeout, bit 2 enables write-protect.
- R11: While busy, only `ce_n_o[cs_i]` is low. While idle, all enables are high.
- R12: `start_i` while busy is ignored. Changing the inputs after the start has no effect on a run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; inputs are captured when it is taken |
| ops_i | input | NUM_OPS*4 | Opcode list, slot 0 in the low bits |
| cmd_i | input | 32 | Four command byte slots |
| col_i | input | COLW+1 | Column; top bit selects the spare area |
| row_i | input | ROWW | Row address |
| cnt_i | input | CNTW | Data byte count, 0 means full page plus spare |
| tmo_i | input | TMOW | Ready-wait limit in cycles |
| cs_i | input | log2(BANKS) | Bank select |
| irq_en_i | input | 3 | Event interrupt enables |
| wp_n_i | input | 1 | Device write-protect, active low |
| wr_data_i | input | 8 | Write burst data |
| rd_data_o | output | 8 | Read burst data |
| rd_valid_o | output | 1 | Read byte valid |
| status_o | output | 32 | Status byte in bits 31:24 |
| busy_o | output | 1 | Run in progress |
| ev_done_o | output | 1 | Completion event |
| ev_tmo_o | output | 1 | Busy timeout event |
| ev_wp_o | output | 1 | Write-protect event |
| irq_o | output | 1 | Masked event interrupt |
| nand_io_o | output | 8 | Bus data out |
| nand_io_i | input | 8 | Bus data in |
| nand_io_oe_o | output | 1 | Bus output enable |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Write strobe, active low |
| re_n_o | output | 1 | Read strobe, active low |
| ce_n_o | output | BANKS | Chip enables, active low |
| rb_n_i | input | 1 | Ready/busy, low while busy |

## Verification
A wrong program counter or opcode decode shows up on the first bus byte after the bad step. That byte is then the wrong command, the wrong address byte or the wrong count. The bench compares every strobe against an expected stream, so such an error is caught within two clocks of the strobe. A stuck ready-wait counter shows up either as an early error event or as a run that never ends. A missed write-protect check shows up as a write strobe where none should be. Event and enable mix-ups appear on the event and interrupt pins as soon as the run leaves busy.

// File: rtl/nand_opseq_pkg.sv
package nand_opseq_pkg;

    localparam int OPW = 4;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_CMD0 = 4'd1,
        OP_CMD1 = 4'd2,
        OP_CMD2 = 4'd3,
        OP_CMD3 = 4'd4,
        OP_COL  = 4'd5,
        OP_ROW  = 4'd6,
        OP_RDW  = 4'd7,
        OP_WRW  = 4'd8,
        OP_STAT = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        BK_CMD   = 2'd0,
        BK_ADDR  = 2'd1,
        BK_WDATA = 2'd2,
        BK_RDATA = 2'd3
    } bytek_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_WAIT,
        SQ_XFER,
        SQ_END
    } sq_e;

    typedef struct packed {
        logic ev_wp;
        logic ev_tmo;
        logic ev_done;
    } events_t;

    function automatic bytek_e kind_of(op_e op);
        case (op)
            OP_COL, OP_ROW:  return BK_ADDR;
            OP_WRW:          return BK_WDATA;
            OP_RDW, OP_STAT: return BK_RDATA;
            default:         return BK_CMD;
        endcase
    endfunction

endpackage

// File: rtl/nand_opseq_rbwait.sv
module nand_opseq_rbwait #(
    parameter int TMOW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic            rb_n_i,
    input  logic [TMOW-1:0] limit_i,
    output logic            ready_o,
    output logic            expired_o
);
    logic [TMOW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q <= '0;
        end else if (!rb_n_i && cnt_q != limit_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready_o   = en_i && rb_n_i;
    assign expired_o = en_i && !rb_n_i && (cnt_q == limit_i);

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (rst)
        en_i |-> (cnt_q <= limit_i)); // R8
endmodule

// File: rtl/nand_opseq_phy.sv
module nand_opseq_phy
    import nand_opseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  bytek_e     kind_i,
    input  logic [7:0] byte_i,
    output logic       ready_o,
    output logic       done_o,
    output logic [7:0] rdata_o,
    output logic       cle_o,
    output logic       ale_o,
    output logic       we_n_o,
    output logic       re_n_o,
    output logic [7:0] io_o,
    output logic       io_oe_o,
    input  logic [7:0] io_i
);
    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;

    ph_e        ph_q;
    bytek_e     kind_q;
    logic [7:0] byte_q;
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            kind_q  <= BK_CMD;
            byte_q  <= '0;
            rdata_q <= '0;
        end else begin
            case (ph_q)
                PH_LOW: begin
                    ph_q <= PH_HIGH;
                    if (kind_q == BK_RDATA) rdata_q <= io_i;
                end
                default: begin
                    if (go_i) begin
                        ph_q   <= PH_LOW;
                        kind_q <= kind_i;
                        byte_q <= byte_i;
                    end else begin
                        ph_q <= PH_IDLE;
                    end
                end
            endcase
        end
    end

    assign ready_o = (ph_q != PH_LOW);
    assign done_o  = (ph_q == PH_HIGH);
    assign rdata_o = rdata_q;
    assign cle_o   = (ph_q != PH_IDLE) && (kind_q == BK_CMD);
    assign ale_o   = (ph_q != PH_IDLE) && (kind_q == BK_ADDR);
    assign we_n_o  = !((ph_q == PH_LOW) && (kind_q != BK_RDATA));
    assign re_n_o  = !((ph_q == PH_LOW) && (kind_q == BK_RDATA));
    assign io_o    = byte_q;
    assign io_oe_o = (ph_q != PH_IDLE) && (kind_q != BK_RDATA);

    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !we_n_o |=> we_n_o); // R3
    AST_RE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !re_n_o |=> re_n_o); // R5
endmodule

// File: rtl/nand_opseq.sv
module nand_opseq
    import nand_opseq_pkg::*;
#(
    parameter int NUM_OPS     = 9,
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int BANKS       = 4,
    parameter int COLW        = 12,
    parameter int ROWW        = 24,
    parameter int CNTW        = 16,
    parameter int TMOW        = 16,
    localparam int PCW        = $clog2(NUM_OPS),
    localparam int CSW        = $clog2(BANKS),
    localparam int ROW_BYTES  = ROWW / 8,
    localparam int FULL_BYTES = PAGE_BYTES + SPARE_BYTES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [NUM_OPS*OPW-1:0] ops_i,
    input  logic [31:0]            cmd_i,
    input  logic [COLW:0]          col_i,
    input  logic [ROWW-1:0]        row_i,
    input  logic [CNTW-1:0]        cnt_i,
    input  logic [TMOW-1:0]        tmo_i,
    input  logic [CSW-1:0]         cs_i,
    input  logic [2:0]             irq_en_i,
    input  logic                   wp_n_i,
    input  logic [7:0]             wr_data_i,
    output logic [7:0]             rd_data_o,
    output logic                   rd_valid_o,
    output logic [31:0]            status_o,
    output logic                   busy_o,
    output logic                   ev_done_o,
    output logic                   ev_tmo_o,
    output logic                   ev_wp_o,
    output logic                   irq_o,
    output logic [7:0]             nand_io_o,
    input  logic [7:0]             nand_io_i,
    output logic                   nand_io_oe_o,
    output logic                   cle_o,
    output logic                   ale_o,
    output logic                   we_n_o,
    output logic                   re_n_o,
    output logic [BANKS-1:0]       ce_n_o,
    input  logic                   rb_n_i
);
    sq_e                    st_q;
    logic [PCW-1:0]         pc_q;
    logic [NUM_OPS*OPW-1:0] ops_q;
    logic [31:0]            cmd_q;
    logic [COLW:0]          col_q;
    logic [ROWW-1:0]        row_q;
    logic [CNTW-1:0]        cnt_q;
    logic [TMOW-1:0]        tmo_q;
    logic [CSW-1:0]         cs_q;
    op_e                    op_q;
    logic [CNTW-1:0]        remain_q;
    logic [1:0]             bidx_q;
    logic [31:0]            status_q;
    events_t                ev_q;

    op_e        cur_op;
    logic       go, phy_ready, phy_done;
    logic [7:0] phy_rdata, tx_byte;
    logic [15:0] col_addr;
    logic       tmr_ready, tmr_exp;
    logic [CNTW-1:0] burst_len;

    assign cur_op    = op_e'(ops_q[int'(pc_q)*OPW +: OPW]);
    assign burst_len = (cnt_q == '0) ? CNTW'(FULL_BYTES) : cnt_q;
    assign col_addr  = 16'(col_q[COLW-1:0]) + (col_q[COLW] ? 16'(PAGE_BYTES) : 16'd0);
    assign go        = (st_q == SQ_XFER) && (remain_q != '0) && phy_ready;

    always_comb begin
        case (op_q)
            OP_CMD0: tx_byte = cmd_q[7:0];
            OP_CMD1: tx_byte = cmd_q[15:8];
            OP_CMD2: tx_byte = cmd_q[23:16];
            OP_CMD3: tx_byte = cmd_q[31:24];
            OP_COL:  tx_byte = bidx_q[0] ? col_addr[15:8] : col_addr[7:0];
            OP_ROW:  tx_byte = row_q[{bidx_q, 3'b000} +: 8];
            OP_WRW:  tx_byte = wr_data_i;
            default: tx_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SQ_IDLE;
            pc_q     <= '0;
            ops_q    <= '0;
            cmd_q    <= '0;
            col_q    <= '0;
            row_q    <= '0;
            cnt_q    <= '0;
            tmo_q    <= '0;
            cs_q     <= '0;
            op_q     <= OP_NOP;
            remain_q <= '0;
            bidx_q   <= '0;
            status_q <= '0;
            ev_q     <= '0;
        end else begin
            if (go) begin
                remain_q <= remain_q - 1'b1;
                bidx_q   <= bidx_q + 1'b1;
            end
            case (st_q)
                SQ_IDLE: if (start_i) begin
                    ops_q <= ops_i;
                    cmd_q <= cmd_i;
                    col_q <= col_i;
                    row_q <= row_i;
                    cnt_q <= cnt_i;
                    tmo_q <= tmo_i;
                    cs_q  <= cs_i;
                    pc_q  <= '0;
                    ev_q  <= '0;
                    st_q  <= SQ_FETCH;
                end
                SQ_FETCH: begin
                    op_q   <= cur_op;
                    bidx_q <= '0;
                    case (cur_op)
                        OP_CMD0, OP_CMD1, OP_CMD2, OP_CMD3: begin
                            remain_q <= CNTW'(1);
                            st_q     <= SQ_XFER;
                        end
                        OP_COL: begin
                            remain_q <= CNTW'(2);
                            st_q     <= SQ_XFER;
                        end
                        OP_ROW: begin
                            remain_q <= CNTW'(ROW_BYTES);
                            st_q     <= SQ_XFER;
                        end
                        OP_RDW: begin
                            remain_q <= burst_len;
                            st_q     <= SQ_WAIT;
                        end
                        OP_STAT: begin
                            remain_q <= CNTW'(1);
                            st_q     <= SQ_WAIT;
                        end
                        OP_WRW: begin
                            remain_q <= burst_len;
                            if (!wp_n_i) begin
                                ev_q.ev_wp <= 1'b1;
                                st_q       <= SQ_IDLE;
                            end else begin
                                st_q <= SQ_WAIT;
                            end
                        end
                        default: st_q <= SQ_END;
                    endcase
                end
                SQ_WAIT: begin
                    if (tmr_ready) begin
                        st_q <= SQ_XFER;
                    end else if (tmr_exp) begin
                        ev_q.ev_tmo <= 1'b1;
                        st_q        <= SQ_IDLE;
                    end
                end
                SQ_XFER: begin
                    if (phy_done && op_q == OP_STAT) status_q <= {phy_rdata, 24'h0};
                    if (phy_done && remain_q == '0) begin
                        if (pc_q == PCW'(NUM_OPS - 1)) begin
                            st_q <= SQ_END;
                        end else begin
                            pc_q <= pc_q + 1'b1;
                            st_q <= SQ_FETCH;
                        end
                    end
                end
                default: begin
                    ev_q.ev_done <= 1'b1;
                    st_q         <= SQ_IDLE;
                end
            endcase
        end
    end

    nand_opseq_rbwait #(.TMOW(TMOW)) u_wait (
        .clk       (clk),
        .rst       (rst),
        .en_i      (st_q == SQ_WAIT),
        .rb_n_i    (rb_n_i),
        .limit_i   (tmo_q),
        .ready_o   (tmr_ready),
        .expired_o (tmr_exp)
    );

    nand_opseq_phy u_phy (
        .clk     (clk),
        .rst     (rst),
        .go_i    (go),
        .kind_i  (kind_of(op_q)),
        .byte_i  (tx_byte),
        .ready_o (phy_ready),
        .done_o  (phy_done),
        .rdata_o (phy_rdata),
        .cle_o   (cle_o),
        .ale_o   (ale_o),
        .we_n_o  (we_n_o),
        .re_n_o  (re_n_o),
        .io_o    (nand_io_o),
        .io_oe_o (nand_io_oe_o),
        .io_i    (nand_io_i)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_ce
        assign ce_n_o[b] = !((st_q != SQ_IDLE) && (cs_q == CSW'(b)));
    end

    assign busy_o     = (st_q != SQ_IDLE);
    assign rd_valid_o = (st_q == SQ_XFER) && phy_done && (op_q == OP_RDW);
    assign rd_data_o  = phy_rdata;
    assign status_o   = status_q;
    assign ev_done_o  = ev_q.ev_done;
    assign ev_tmo_o   = ev_q.ev_tmo;
    assign ev_wp_o    = ev_q.ev_wp;
    assign irq_o      = |(ev_q & irq_en_i);

    AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ce_n_o)); // R11
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ev_done_o && (ev_tmo_o || ev_wp_o))); // R8
    AST_WP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (ev_wp_o && !busy_o) |-> (we_n_o && !cle_o && !ale_o)); // R9
    AST_BUSY_START_KEEP: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ($stable(ops_q) && $stable(cmd_q) && $stable(cs_q))); // R12
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !ev_done_o && !ev_tmo_o && !ev_wp_o)); // R2
endmodule

// File: tb/nand_opseq_tb_top.sv
module nand_opseq_tb_top;
    import nand_opseq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PG = 32;
    localparam int SP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [35:0] ops_i = '0;
    logic [31:0] cmd_i = '0;
    logic [12:0] col_i = '0;
    logic [23:0] row_i = '0;
    logic [15:0] cnt_i = '0;
    logic [15:0] tmo_i = 16'd50;
    logic [1:0]  cs_i = '0;
    logic [2:0]  irq_en_i = '0;
    logic        wp_n_i = 1'b1;
    logic [7:0]  wr_val = 8'hA0;
    logic [7:0]  rd_val = 8'h40;
    logic        rb_n_i = 1'b1;
    logic [7:0]  rd_data_o, nand_io_o;
    logic        rd_valid_o, busy_o, ev_done_o, ev_tmo_o, ev_wp_o, irq_o;
    logic        nand_io_oe_o, cle_o, ale_o, we_n_o, re_n_o;
    logic [31:0] status_o;
    logic [3:0]  ce_n_o;

    nand_opseq #(.PAGE_BYTES(PG), .SPARE_BYTES(SP)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .ops_i(ops_i), .cmd_i(cmd_i),
        .col_i(col_i), .row_i(row_i), .cnt_i(cnt_i), .tmo_i(tmo_i), .cs_i(cs_i),
        .irq_en_i(irq_en_i), .wp_n_i(wp_n_i), .wr_data_i(wr_val),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .status_o(status_o),
        .busy_o(busy_o), .ev_done_o(ev_done_o), .ev_tmo_o(ev_tmo_o), .ev_wp_o(ev_wp_o),
        .irq_o(irq_o), .nand_io_o(nand_io_o), .nand_io_i(rd_val),
        .nand_io_oe_o(nand_io_oe_o), .cle_o(cle_o), .ale_o(ale_o), .we_n_o(we_n_o),
        .re_n_o(re_n_o), .ce_n_o(ce_n_o), .rb_n_i(rb_n_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    logic [9:0] exp_q[$];
    logic [7:0] exp_wr, exp_rd;
    int  rb_cnt = 0;
    bit  rd_pend = 0;
    logic [3:0] prg[9];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic take(input logic [9:0] obs, input string tag);
        logic [9:0] e;
        if (exp_q.size() == 0) begin
            chk(1'b0, {tag, " unexpected byte"}, 32'(obs), 32'h3ff);
        end else begin
            e = exp_q.pop_front();
            chk(obs == e, tag, 32'(obs), 32'(e));
        end
    endtask

    // monitor and device model
    always @(negedge clk) begin
        if (!rst) begin
            if (!we_n_o) begin
                if (cle_o)      take({2'd0, nand_io_o}, "R2 command byte");
                else if (ale_o) take({2'd1, nand_io_o}, "R3 address byte");
                else begin
                    take({2'd2, nand_io_o}, "R6 write byte");
                    wr_val = wr_val + 8'd1;
                end
            end
            if (rd_valid_o) take({2'd3, rd_data_o}, "R5 read byte");
            if (!re_n_o) rd_pend = 1'b1;
            else if (rd_pend) begin
                rd_val  = rd_val + 8'd1;
                rd_pend = 1'b0;
            end
            if (rb_cnt > 0) rb_cnt = rb_cnt - 1;
            rb_n_i = (rb_cnt == 0);
        end
    end

    task automatic ex(input logic [1:0] k, input logic [7:0] b);
        exp_q.push_back({k, b});
    endtask
    task automatic ex_rd(input int n);
        for (int i = 0; i < n; i++) begin ex(2'd3, exp_rd); exp_rd = exp_rd + 8'd1; end
    endtask
    task automatic ex_wr(input int n);
        for (int i = 0; i < n; i++) begin ex(2'd2, exp_wr); exp_wr = exp_wr + 8'd1; end
    endtask

    task automatic load_prg();
        for (int k = 0; k < 9; k++) ops_i[k*4 +: 4] = prg[k];
        exp_wr = wr_val;
        exp_rd = rd_val;
    endtask

    task automatic kick();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic finish_run(input string tag);
        int n = 0;
        while (busy_o && n < 5000) begin @(negedge clk); n++; end
        chk(!busy_o, {tag, " run ends"}, 32'(busy_o), 32'd0);
        @(negedge clk);
        chk(exp_q.size() == 0, {tag, " all expected bytes seen"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R1 watchdog expired actual=1 expected=0");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !ev_done_o && !ev_tmo_o && !ev_wp_o && !irq_o, "R1 idle and events clear",
            {busy_o, ev_done_o, ev_tmo_o, ev_wp_o, irq_o}, 0);
        chk(we_n_o && re_n_o && ce_n_o == 4'hF, "R1 strobes high", {we_n_o, re_n_o, ce_n_o}, 6'h3F);
        chk(status_o == 0, "R1 status zero", status_o, 0);

        // large-page read: R2 R3 R5 R10
        prg = '{OP_CMD0, OP_COL, OP_ROW, OP_CMD1, OP_RDW, OP_NOP, OP_NOP, OP_NOP, OP_NOP};
        load_prg();
        cmd_i = 32'h0000_3000; col_i = 13'd3; row_i = 24'h123456; cnt_i = 16'd5;
        cs_i = 2'd0; irq_en_i = 3'b001; rb_cnt = 10;
        ex(0, 8'h00); ex(1, 8'h03); ex(1, 8'h00); ex(1, 8'h56); ex(1, 8'h34); ex(1, 8'h12);
        ex(0, 8'h30); ex_rd(5);
        kick();
        finish_run("R5 large-page read");
        chk(ev_done_o && !ev_tmo_o, "R2 done event", {ev_done_o, ev_tmo_o}, 2'b10);
        chk(irq_o, "R10 done irq enabled", irq_o, 1);
        irq_en_i = 3'b110;
        @(negedge clk);
        chk(!irq_o, "R10 done irq masked", irq_o, 0);

        // small-page spare read, count 0: R4 R5
        prg = '{OP_CMD0, OP_COL, OP_ROW, OP_RDW, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP};
        load_prg();
        cmd_i = 32'h0000_0050; col_i = {1'b1, 12'd5}; row_i = 24'h000201; cnt_i = 16'd0;
        ex(0, 8'h50); ex(1, 8'h25); ex(1, 8'h00); ex(1, 8'h01); ex(1, 8'h02); ex(1, 8'h00);
        ex_rd(PG + SP);
        kick();
        finish_run("R4 spare read full length");

        // erase on bank 2: R11
        prg = '{OP_CMD0, OP_ROW, OP_CMD1, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP};
        load_prg();
        cmd_i = 32'h0000_D060; row_i = 24'h0A0B0C; cs_i = 2'd2;
        ex(0, 8'h60); ex(1, 8'h0C); ex(1, 8'h0B); ex(1, 8'h0A); ex(0, 8'hD0);
        kick();
        @(negedge clk);
        chk(ce_n_o == 4'b1011, "R11 selected bank enable", ce_n_o, 4'b1011);
        finish_run("R11 erase");
        chk(ce_n_o == 4'hF, "R11 enables high when idle", ce_n_o, 4'hF);

        // program with status read: R6 R7
        prg = '{OP_CMD0, OP_COL, OP_ROW, OP_WRW, OP_CMD2, OP_CMD1, OP_STAT, OP_NOP, OP_NOP};
        load_prg();
        cmd_i = 32'h0010_7080; col_i = 13'd0; row_i = 24'h000005; cnt_i = 16'd4; cs_i = 2'd0;
        rb_cnt = 4;
        ex(0, 8'h80); ex(1, 8'h00); ex(1, 8'h00); ex(1, 8'h05); ex(1, 8'h00); ex(1, 8'h00);
        ex_wr(4); ex(0, 8'h10); ex(0, 8'h70);
        kick();
        finish_run("R6 program");
        chk(status_o == {exp_rd, 24'h0}, "R7 status byte placement", status_o, {exp_rd, 24'h0});

        // nine command slots, last slot ends: R2
        prg = '{OP_CMD3, OP_CMD2, OP_CMD1, OP_CMD0, OP_CMD3, OP_CMD3, OP_CMD2, OP_CMD1, OP_CMD0};
        load_prg();
        cmd_i = 32'hFF_EE_DD_CC;
        ex(0, 8'hFF); ex(0, 8'hEE); ex(0, 8'hDD); ex(0, 8'hCC); ex(0, 8'hFF);
        ex(0, 8'hFF); ex(0, 8'hEE); ex(0, 8'hDD); ex(0, 8'hCC);
        kick();
        finish_run("R2 last slot");
        chk(ev_done_o, "R2 done after slot 8", ev_done_o, 1);

        // busy timeout: R8 R10
        prg = '{OP_CMD0, OP_RDW, OP_CMD1, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP};
        load_prg();
        cmd_i = 32'h0000_3000; cnt_i = 16'd3; tmo_i = 16'd20; irq_en_i = 3'b010;
        rb_cnt = 100000;
        ex(0, 8'h00);
        kick();
        finish_run("R8 timeout");
        chk(ev_tmo_o && !ev_done_o, "R8 timeout event", {ev_tmo_o, ev_done_o}, 2'b10);
        chk(irq_o, "R10 timeout irq", irq_o, 1);
        rb_cnt = 0;
        @(negedge clk);

        // write protect: R9
        prg = '{OP_CMD0, OP_COL, OP_WRW, OP_CMD1, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP};
        load_prg();
        cmd_i = 32'h0000_1080; col_i = 13'd7; cnt_i = 16'd2; wp_n_i = 1'b0; irq_en_i = 3'b100;
        ex(0, 8'h80); ex(1, 8'h07); ex(1, 8'h00);
        kick();
        finish_run("R9 write protect");
        chk(ev_wp_o && !ev_done_o, "R9 write-protect event", {ev_wp_o, ev_done_o}, 2'b10);
        chk(irq_o, "R10 write-protect irq", irq_o, 1);
        wp_n_i = 1'b1;

        // start while busy ignored: R12
        prg = '{OP_CMD0, OP_RDW, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP, OP_NOP};
        load_prg();
        cmd_i = 32'h0000_0011; cnt_i = 16'd3; tmo_i = 16'd100; rb_cnt = 30;
        ex(0, 8'h11); ex_rd(3);
        kick();
        repeat (5) @(negedge clk);
        ops_i = {9{OP_CMD3}}; cmd_i = 32'h99_99_99_99;
        kick();
        finish_run("R12 restart ignored");
        chk(ev_done_o, "R12 first run completes", ev_done_o, 1);

        report();
    end
endmodule